// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block masters the bus of a byte-wide parallel flash device for a client that issues one request at a time. A request carries an operation, a target address, a data byte and a read length. For a byte program or a block erase, the sequencer writes the two-cycle command pair. It then reads the status byte until the ready flag is set, decodes the error flags in a fixed priority, clears the status after a failure, and returns the device to array-read mode. The outcome is reported as a one-cycle `done` pulse that carries a 3-bit result code.

For a suspend request, the block stops an erase that is already running. If the device confirms the suspension, the block switches to array reads and streams the requested number of bytes from consecutive addresses out of a valid/ready port. It then resumes the erase. Every bus phase (address/data setup, write-enable pulse, hold, output-enable access and the idle gap between reads) lasts a parameterised number of clock cycles. A poll limit ends an operation that never becomes ready.

Request port rules: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Read port rules: once `rd_valid` rises, it stays high and `rd_data` holds its value until a clock edge where `rd_ready` is high. The sequencer performs the next bus read only after that edge, so a stalled consumer holds the erase in its suspended state.

Top module: `flash_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. `req_op` encodes 0 = byte program, 1 = block erase, 2 = erase suspend. `done` is a single-cycle pulse, and `req_ready` is 1 in the cycle after it.
- R2: During a bus write, `bus_ce_n` is low, `bus_oe_n` is high and `bus_we_n` pulses low. `bus_we_n` and `bus_oe_n` are never low in the same cycle, and `bus_we_n` is never low while `bus_ce_n` is high.
- R3: A byte program writes 40h to the request address and then writes the request data byte to the same address.
- R4: A block erase writes 20h and then D0h, both to the request address.
- R5: Status is read repeatedly until bit 7 is 1. Between any two reads, both `bus_ce_n` and `bus_oe_n` return high, so every read produces a new falling edge of the later of the two.
- R6: Once bit 7 is set, the result is chosen in this priority order. Bit 3 set gives code 1 (supply range). Otherwise bits 5 and 4 both set give code 2 (bad command sequence). Otherwise bit 5 gives code 3 (erase fault). Otherwise bit 4 gives code 4 (program fault). Otherwise the result is code 0 (success).
- R7: When a program or erase ends with a nonzero code, the block writes 50h to clear the status before the final read-array write.
- R8: A program or erase that reaches a ready status ends with a write of FFh, and this is its last bus write before `done`.
- R9: If POLL_LIMIT status reads all show bit 7 at 0, the result is code 5 and no further bus write follows.
- R10: For a suspend request, the block writes B0h and polls until bit 7 is 1. If bit 6 is 1, it writes FFh, reads `req_len` bytes starting at the request address, writes D0h and reports code 6.
- R11: For a suspend request where bit 6 reads 0 once the device is ready, the block writes FFh and reports code 7 without reading or resuming.
- R12: Each byte read in the suspend window is presented on `rd_data`, where it follows the read port rules, and the next address is read only after the transfer.
- R13: During and immediately after reset, the bus is idle (`bus_ce_n`, `bus_oe_n` and `bus_we_n` all 1), `done` and `rd_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation: 0 program, 1 erase, 2 suspend |
| req_addr | input | AW | Target byte or block address |
| req_data | input | 8 | Byte to program |
| req_len | input | LW | Number of bytes to read in the suspend window |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid while done is 1 |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| bus_ce_n | output | 1 | Flash chip enable, active low |
| bus_oe_n | output | 1 | Flash output enable, active low |
| bus_we_n | output | 1 | Flash write enable, active low |
| bus_drive | output | 1 | Enables the data pad drivers during writes |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Data driven to the flash |
| bus_rdata | input | 8 | Data returned by the flash |

## Verification
Each bus access costs one launch cycle plus SETUP+PULSE+HOLD cycles for a write or READ+GAP cycles for a read. The number of accesses depends on how long the device stays busy, so the time to `done` is data-dependent rather than fixed. The bench therefore samples every falling clock edge and takes `result` on the one edge where `done` is high, inside a bounded window. It also checks `req_ready` one cycle after acceptance and one cycle after `done`. A bus model checks command order and status-read count: it latches status only on a fresh enable edge, so a sequencer that skips the enable toggle reads stale busy status and runs into the poll limit. Read bytes are compared at the edge where `rd_ready` is raised, after some edges where `rd_ready` is held low to confirm the byte does not change.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_SUSP  = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_VPP      = 3'd1,
    RES_SEQ      = 3'd2,
    RES_ERASE    = 3'd3,
    RES_PROG     = 3'd4,
    RES_TIMEOUT  = 3'd5,
    RES_RESUMED  = 3'd6,
    RES_NOT_SUSP = 3'd7
  } res_e;

  localparam logic [DW-1:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [DW-1:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [DW-1:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [DW-1:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [DW-1:0] CMD_CLEAR       = 8'h50;
  localparam logic [DW-1:0] CMD_READ_ARRAY  = 8'hFF;

  localparam int SR_RDY  = 7;
  localparam int SR_SUSP = 6;
  localparam int SR_ERS  = 5;
  localparam int SR_PRG  = 4;
  localparam int SR_VPP  = 3;
endpackage

// File: rtl/fsq_bus.sv
module fsq_bus #(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int READ_CYC  = 3,
  parameter int GAP_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata_q,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          drive,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam int M1   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > GAP_CYC) ? M3 : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {P_IDLE, P_WSET, P_WPUL, P_WHLD, P_RACT, P_RGAP} ph_e;

  ph_e           ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;

  function automatic logic [CW-1:0] ld(input int n);
    return CW'(n - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= P_IDLE;
      cnt     <= '0;
      a_q     <= '0;
      d_q     <= '0;
      rdata_q <= '0;
    end else begin
      case (ph)
        P_IDLE: if (start) begin
          a_q <= addr;
          d_q <= wdata;
          if (is_wr) begin ph <= P_WSET; cnt <= ld(SETUP_CYC); end
          else       begin ph <= P_RACT; cnt <= ld(READ_CYC);  end
        end
        P_WSET: if (cnt == '0) begin ph <= P_WPUL; cnt <= ld(PULSE_CYC); end
                else cnt <= cnt - 1'b1;
        P_WPUL: if (cnt == '0) begin ph <= P_WHLD; cnt <= ld(HOLD_CYC); end
                else cnt <= cnt - 1'b1;
        P_WHLD: if (cnt == '0) ph <= P_IDLE;
                else cnt <= cnt - 1'b1;
        P_RACT: if (cnt == '0) begin
                  rdata_q <= bus_rdata;
                  ph      <= P_RGAP;
                  cnt     <= ld(GAP_CYC);
                end else cnt <= cnt - 1'b1;
        P_RGAP: if (cnt == '0) ph <= P_IDLE;
                else cnt <= cnt - 1'b1;
        default: ph <= P_IDLE;
      endcase
    end
  end

  always_comb begin
    ce_n      = !(ph inside {P_WSET, P_WPUL, P_WHLD, P_RACT});
    oe_n      = (ph != P_RACT);
    we_n      = (ph != P_WPUL);
    drive     = ph inside {P_WSET, P_WPUL, P_WHLD};
    done      = (cnt == '0) && (ph inside {P_WHLD, P_RGAP});
    bus_addr  = a_q;
    bus_wdata = d_q;
  end

  // R2: write strobe and output enable never overlap
  assert_no_we_oe_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  // R2: write strobe only inside a chip-enable window
  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  // R5: each read starts from a deselected bus
  assert_read_after_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> $past(ce_n));
endmodule

// File: rtl/fsq_decode.sv
module fsq_decode
  import fsq_pkg::*;
(
  input  logic [2:0] err_bits,   // {erase fault, program fault, supply fault}
  output res_e       code
);
  always_comb begin
    if (err_bits[0])                     code = RES_VPP;
    else if (err_bits[2] && err_bits[1]) code = RES_SEQ;
    else if (err_bits[2])                code = RES_ERASE;
    else if (err_bits[1])                code = RES_PROG;
    else                                 code = RES_OK;
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import fsq_pkg::*;
#(
  parameter int AW         = 17,
  parameter int LW         = 4,
  parameter int POLL_LIMIT = 4096,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int HOLD_CYC   = 1,
  parameter int READ_CYC   = 3,
  parameter int GAP_CYC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [LW-1:0] req_len,
  output logic          done,
  output logic [2:0]    result,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          bus_ce_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic          bus_drive,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_CMD2, S_POLL, S_CHECK, S_CLR, S_ARR,
    S_SFF, S_RD, S_RDOUT, S_RESUME, S_DONE
  } st_e;

  st_e            state;
  logic [1:0]     op_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [LW-1:0]  len_q;
  logic [LW-1:0]  rd_idx;
  logic [PCW-1:0] poll_cnt;
  logic           launched;
  logic           susp_q;
  logic [2:0]     err_q;
  res_e           res_q;
  res_e           dec_code;
  logic           rd_valid_q;
  logic [DW-1:0]  rd_data_q;

  logic           b_start, b_wr, b_done;
  logic [AW-1:0]  b_addr;
  logic [DW-1:0]  b_wdata, b_rdata;

  fsq_bus #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .READ_CYC(READ_CYC), .GAP_CYC(GAP_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(b_start), .is_wr(b_wr),
    .addr(b_addr), .wdata(b_wdata), .done(b_done), .rdata_q(b_rdata),
    .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n), .drive(bus_drive),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  fsq_decode u_dec (.err_bits(err_q), .code(dec_code));

  always_comb begin
    b_start = (state inside {S_CMD1, S_CMD2, S_POLL, S_CLR, S_ARR, S_SFF, S_RD, S_RESUME})
              && !launched;
    b_wr    = !(state inside {S_POLL, S_RD});
    b_addr  = (state == S_RD) ? addr_q + AW'(rd_idx) : addr_q;
    case (state)
      S_CMD1:       b_wdata = (op_q == OP_ERASE) ? CMD_ERASE_SETUP :
                              (op_q == OP_SUSP)  ? CMD_SUSPEND : CMD_PROG_SETUP;
      S_CMD2:       b_wdata = (op_q == OP_ERASE) ? CMD_CONFIRM : data_q;
      S_CLR:        b_wdata = CMD_CLEAR;
      S_ARR, S_SFF: b_wdata = CMD_READ_ARRAY;
      S_RESUME:     b_wdata = CMD_CONFIRM;
      default:      b_wdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      len_q      <= '0;
      rd_idx     <= '0;
      poll_cnt   <= '0;
      launched   <= 1'b0;
      susp_q     <= 1'b0;
      err_q      <= '0;
      res_q      <= RES_OK;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (b_start) launched <= 1'b1;
      if (b_done)  launched <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q     <= req_op;
          addr_q   <= req_addr;
          data_q   <= req_data;
          len_q    <= req_len;
          rd_idx   <= '0;
          poll_cnt <= '0;
          state    <= S_CMD1;
        end
        S_CMD1: if (b_done) state <= (op_q == OP_SUSP) ? S_POLL : S_CMD2;
        S_CMD2: if (b_done) state <= S_POLL;
        S_POLL: if (b_done) begin
          if (b_rdata[SR_RDY]) begin
            susp_q <= b_rdata[SR_SUSP];
            err_q  <= {b_rdata[SR_ERS], b_rdata[SR_PRG], b_rdata[SR_VPP]};
            state  <= S_CHECK;
          end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
            res_q <= RES_TIMEOUT;
            state <= S_DONE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        S_CHECK: begin
          if (op_q == OP_SUSP) begin
            if (susp_q) state <= S_SFF;
            else begin res_q <= RES_NOT_SUSP; state <= S_ARR; end
          end else begin
            res_q <= dec_code;
            state <= (dec_code == RES_OK) ? S_ARR : S_CLR;
          end
        end
        S_CLR: if (b_done) state <= S_ARR;
        S_ARR: if (b_done) state <= S_DONE;
        S_SFF: if (b_done) state <= (len_q == '0) ? S_RESUME : S_RD;
        S_RD:  if (b_done) begin
          rd_data_q  <= b_rdata;
          rd_valid_q <= 1'b1;
          state      <= S_RDOUT;
        end
        S_RDOUT: if (rd_ready) begin
          rd_valid_q <= 1'b0;
          if (rd_idx == len_q - LW'(1)) state <= S_RESUME;
          else begin rd_idx <= rd_idx + 1'b1; state <= S_RD; end
        end
        S_RESUME: if (b_done) begin res_q <= RES_RESUMED; state <= S_DONE; end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign result    = res_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

  // R1: completion is a single-cycle pulse followed by readiness
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R12: an unaccepted read byte is held
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R9: poll counter stays inside its window
  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> (poll_cnt < PCW'(POLL_LIMIT)));
  // R1: no request is taken while a bus access is outstanding
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce_n |-> !req_ready);
endmodule

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
  localparam int AW = 17, LW = 4, PLIM = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, req_ready, done, rd_valid, rd_ready;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr, bus_addr;
  logic [7:0] req_data, rd_data, bus_wdata, bus_rdata;
  logic [LW-1:0] req_len;
  logic [2:0] result;
  logic bus_ce_n, bus_oe_n, bus_we_n, bus_drive;

  flash_seq #(.AW(AW), .LW(LW), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .done(done), .result(result), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_drive(bus_drive), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // ---------------- flash bus model ----------------
  int         cfg_busy = 0;
  logic [7:0] cfg_err = 8'h00;
  bit         cfg_susp = 1'b0;

  logic [7:0] sr_lat = 8'h80, sr_fin = 8'h80;
  int         busy_left = 0, pend = 0, nlat = 0, novl = 0, wn = 0;
  bit         arr_mode = 1'b1, prev_we = 1'b1, prev_act = 1'b0;
  logic [AW-1:0] wl_a [0:255];
  logic [7:0]    wl_d [0:255];

  assign bus_rdata = arr_mode ? (bus_addr[7:0] ^ 8'h5A) : sr_lat;

  always @(negedge clk) begin
    if (!bus_we_n && !bus_oe_n) novl <= novl + 1;
    prev_we  <= bus_we_n;
    prev_act <= !bus_ce_n && !bus_oe_n;
    if (!prev_we && bus_we_n && !bus_ce_n) begin
      wl_a[wn[7:0]] <= bus_addr;
      wl_d[wn[7:0]] <= bus_wdata;
      wn <= wn + 1;
      if (pend == 1 || (pend == 2 && bus_wdata == 8'hD0)) begin
        pend <= 0; busy_left <= cfg_busy; sr_fin <= 8'h80 | cfg_err; arr_mode <= 1'b0;
      end else begin
        case (bus_wdata)
          8'hFF: arr_mode <= 1'b1;
          8'h70: arr_mode <= 1'b0;
          8'h50: sr_fin <= sr_fin & 8'hC7;
          8'h40: begin pend <= 1; arr_mode <= 1'b0; end
          8'h20: begin pend <= 2; arr_mode <= 1'b0; end
          8'hB0: begin busy_left <= cfg_busy; sr_fin <= cfg_susp ? 8'hC0 : 8'h80; arr_mode <= 1'b0; end
          8'hD0: begin sr_fin <= 8'h80; arr_mode <= 1'b0; end
          default: ;
        endcase
      end
    end
    if (!bus_ce_n && !bus_oe_n && !prev_act && !arr_mode) begin
      nlat <= nlat + 1;
      if (busy_left > 0) begin sr_lat <= 8'h00; busy_left <= busy_left - 1; end
      else sr_lat <= sr_fin;
    end
  end

  // ---------------- bench bookkeeping ----------------
  int n_chk = 0, n_fail = 0;
  logic [2:0] got_res;
  int got_n, stable_bad;
  bit got_to;
  logic [7:0] got [0:15];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic [LW-1:0] len, input int bp);
    int hold;
    logic [7:0] held;
    hold = 0; held = 8'h00;
    got_n = 0; stable_bad = 0; got_to = 1'b1; got_res = 3'd0;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 ready low while busy", int'(req_ready), 0);
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (done) begin got_res = result; got_to = 1'b0; break; end
      if (rd_valid) begin
        if (hold > 0 && rd_data != held) stable_bad++;
        if (hold < bp) begin rd_ready = 1'b0; held = rd_data; hold++; end
        else begin rd_ready = 1'b1; got[got_n[3:0]] = rd_data; got_n++; hold = 0; end
      end else rd_ready = 1'b0;
    end
    rd_ready = 1'b0;
    chk(!got_to, "R1 done seen", int'(got_to), 0);
    @(negedge clk);
    chk(req_ready && !done, "R1 ready after done pulse", int'({req_ready, done}), 2);
  endtask

  // op, busy polls, injected error flags, expected code
  localparam logic [20:0] VEC [0:7] = '{
    {2'd0, 8'd2,  8'h00, 3'd0},
    {2'd0, 8'd3,  8'h10, 3'd4},
    {2'd1, 8'd1,  8'h20, 3'd3},
    {2'd1, 8'd4,  8'h30, 3'd2},
    {2'd0, 8'd0,  8'h08, 3'd1},
    {2'd1, 8'd2,  8'h38, 3'd1},
    {2'd0, 8'd19, 8'h18, 3'd1},
    {2'd1, 8'd0,  8'h00, 3'd0}
  };

  initial begin
    int base, lat0;
    rst_n = 1'b0; req_valid = 1'b0; rd_ready = 1'b0;
    req_op = '0; req_addr = '0; req_data = '0; req_len = '0;
    repeat (4) @(negedge clk);
    chk(bus_ce_n && bus_oe_n && bus_we_n && !done && !rd_valid && req_ready,
        "R13 state in reset", int'({bus_ce_n, bus_oe_n, bus_we_n, done, rd_valid, req_ready}), 6'h39);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ce_n && bus_oe_n && bus_we_n && !done && req_ready,
        "R13 state after reset", int'({bus_ce_n, bus_oe_n, bus_we_n, done, req_ready}), 5'h1D);

    for (int i = 0; i < 8; i++) begin
      logic [1:0] op; logic [7:0] busy, err; logic [2:0] exp;
      logic [AW-1:0] a; logic [7:0] d; bit is_err;
      {op, busy, err, exp} = VEC[i];
      a = AW'(17'h01000 + i * 17'h00111); d = 8'hA0 + 8'(i);
      is_err = (exp != 3'd0);
      cfg_busy = int'(busy); cfg_err = err;
      base = wn; lat0 = nlat;
      run_op(op, a, d, '0, 0);
      chk(got_res == exp, "R6 result code", int'(got_res), int'(exp));
      chk(wn - base == (is_err ? 4 : 3), "R8 write count", wn - base, is_err ? 4 : 3);
      if (op == 2'd0) begin
        chk(wl_d[base] == 8'h40 && wl_a[base] == a, "R3 setup byte", int'(wl_d[base]), 8'h40);
        chk(wl_d[base+1] == d && wl_a[base+1] == a, "R3 data byte", int'(wl_d[base+1]), int'(d));
      end else begin
        chk(wl_d[base] == 8'h20 && wl_a[base] == a, "R4 setup byte", int'(wl_d[base]), 8'h20);
        chk(wl_d[base+1] == 8'hD0 && wl_a[base+1] == a, "R4 confirm byte", int'(wl_d[base+1]), 8'hD0);
      end
      if (is_err) chk(wl_d[base+2] == 8'h50, "R7 clear written", int'(wl_d[base+2]), 8'h50);
      chk(wl_d[wn-1] == 8'hFF, "R8 last write", int'(wl_d[wn-1]), 8'hFF);
      chk(nlat - lat0 == int'(busy) + 1, "R5 status reads", nlat - lat0, int'(busy) + 1);
    end

    // R9: device never ready within the limit
    cfg_busy = PLIM; cfg_err = 8'h00; base = wn; lat0 = nlat;
    run_op(2'd0, 17'h00200, 8'h33, '0, 0);
    chk(got_res == 3'd5, "R9 timeout code", int'(got_res), 5);
    chk(wn - base == 2, "R9 no write after timeout", wn - base, 2);
    chk(nlat - lat0 == PLIM, "R9 poll count", nlat - lat0, PLIM);

    // R10 / R12: suspend accepted, three reads with back-pressure
    cfg_busy = 2; cfg_susp = 1'b1; base = wn;
    run_op(2'd2, 17'h00104, 8'h00, 4'd3, 2);
    chk(got_res == 3'd6, "R10 resumed code", int'(got_res), 6);
    chk(got_n == 3, "R12 read count", got_n, 3);
    for (int k = 0; k < 3; k++)
      chk(got[k] == ((8'h04 + 8'(k)) ^ 8'h5A), "R12 read data", int'(got[k]), int'((8'h04 + 8'(k)) ^ 8'h5A));
    chk(stable_bad == 0, "R12 held while stalled", stable_bad, 0);
    chk(wn - base == 3 && wl_d[base] == 8'hB0 && wl_d[base+1] == 8'hFF && wl_d[base+2] == 8'hD0,
        "R10 write order", int'({wl_d[base], wl_d[base+1], wl_d[base+2]}), 24'hB0FFD0);

    // R10: suspend accepted with zero reads
    cfg_busy = 0; base = wn;
    run_op(2'd2, 17'h00300, 8'h00, 4'd0, 0);
    chk(got_res == 3'd6 && got_n == 0, "R10 zero-length window", int'(got_res), 6);
    chk(wn - base == 3 && wl_d[base+2] == 8'hD0, "R10 resume written", wn - base, 3);

    // R11: erase already finished
    cfg_busy = 1; cfg_susp = 1'b0; base = wn;
    run_op(2'd2, 17'h00400, 8'h00, 4'd2, 0);
    chk(got_res == 3'd7, "R11 not-suspended code", int'(got_res), 7);
    chk(got_n == 0, "R11 no reads", got_n, 0);
    chk(wn - base == 2 && wl_d[base] == 8'hB0 && wl_d[base+1] == 8'hFF,
        "R11 write order", int'({wl_d[base], wl_d[base+1]}), 16'hB0FF);

    chk(novl == 0, "R2 write/output enable overlap", novl, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule